// File: doc/BRIEF.md
# Register-mapped UART controller

This block is an asynchronous serial port that software drives through four 32-bit word registers on a simple single-cycle bus. The registers are control, receive data, transmit data and status. Characters written to the transmit data register are queued in a transmit FIFO. A serializer turns each one into a frame. A frame has a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and one or two high stop bits. The receiver looks for a start bit on the serial input, rejects short glitches, rebuilds the character and pushes it into a receive FIFO. Software pops that FIFO by reading the receive data register.

The module clock runs at eight times the baud rate, so every serial bit lasts eight clocks. The block also offers:
- optional RTS/CTS flow control;
- an internal loopback path from the transmitter to the receiver;
- sticky pending and error flags, cleared by writing one;
- one level-high interrupt line.

Top module: `mmio_uart`

## Requirements
- R1: After reset, the control register (offset 0x00) reads 0 and `txd` is high. The status register (offset 0x0C) reads 0x5A2 with `cts_in` held high: bit 1 transmit pending, bit 5 receive FIFO empty, bit 7 CTS, bit 8 RTS and bit 10 transmitter empty are set, and the level field is 0. `irq` is low.
- R2: With control bit 15 set, each byte written to offset 0x08 is sent on `txd` as one frame in which every bit lasts 8 clocks: a start bit of 0, then the data bits least significant first, then the parity bit if one is enabled, then the stop bits of 1. Control bits [1:0] give the word length (0 = 5, 1 = 6, 2 = 7, 3 = 8 bits). Control bit 2 set gives two stop bits instead of one.
- R3: Control field [6:4] selects parity: 0 none, 4 odd (data plus parity has an odd count of ones), 5 always 1, 6 even, 7 always 0.
- R4: With control bit 20 set, the transmitter output feeds the receiver instead of `rxd`, and `txd` stays high.
- R5: With control bit 15 set, a frame received on `rxd` places its data into the receive FIFO, and status bit 5 goes low. A read of offset 0x04 returns the oldest character in bits [7:0] and removes it from the FIFO.
- R6: A received frame whose first stop bit is 0, or whose parity bit mismatches, sets status bit 4. A frame that arrives while the receive FIFO is full is dropped and sets status bit 2. A write to the status register clears each of bits 0 to 4 where the written bit is 1, unless that bit's set condition holds in the same cycle.
- R7: Status bit 6 is set while the transmit FIFO holds TX_DEPTH entries. A write to offset 0x08 while the FIFO is full is dropped and sets status bit 3.
- R8: `irq` is high while status bit 0 is set with control bit 18 set, or while status bit 1 is set with control bit 19 set. Status bit 0 is set in every cycle the receive FIFO is non-empty. Status bit 1 is set in every cycle the transmit FIFO holds fewer than TX_DEPTH/2 entries.
- R9: With control bit 12 set, no new frame starts while `cts_in` is low. `rts_out` (also status bit 8) is low while the receive FIFO has two or fewer free entries. Status bit 7 shows `cts_in`.
- R10: Status bits [16:11] hold the number of entries in the transmit FIFO. Status bit 10 is set only when that FIFO is empty and no frame is being sent.
- R11: A low level on the receive input that lasts less than half a bit period does not start a character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock, eight times the baud rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, idle high |
| cts_in | input | 1 | Clear to send, high = peer may receive |
| rts_out | output | 1 | Request to send, high = room to receive |
| irq | output | 1 | Level-high interrupt |

## Verification
The bench drives four different frame shapes through the transmitter, one for each non-trivial parity mode. Each shape uses a different word length and stop count, so a misplaced parity bit, a wrong parity sense or a lost second stop bit shows up as a wrong bit in the captured frame.

On the receive side, the bench sends one frame with a deliberately wrong parity bit and one glitch shorter than half a bit. A receiver that skipped the mid-start recheck would push a bogus 0xFF character.

Overrun, the full-FIFO write drop and the RTS threshold are tested at their exact entry counts. An off-by-one in any of them changes the flags seen at those counts. The interrupt test clears the receive pending flag after the FIFO is drained, and CTS is held low across a queued character. These show whether the pending flags are sticky and whether flow control holds back the start of a frame.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int unsigned OSR = 8;
  localparam int unsigned TW  = $clog2(OSR);

  localparam logic [2:0] PAR_ODD   = 3'd4;
  localparam logic [2:0] PAR_MARK  = 3'd5;
  localparam logic [2:0] PAR_EVEN  = 3'd6;

  typedef struct packed {
    logic [1:0] wlen;
    logic       two_stop;
    logic [2:0] par;
  } frame_cfg_t;

  function automatic logic [3:0] data_bits(logic [1:0] wlen);
    return 4'd5 + {2'b00, wlen};
  endfunction

  function automatic logic [7:0] data_mask(logic [1:0] wlen);
    return 8'hFF >> (2'd3 - wlen);
  endfunction

  function automatic logic has_par(frame_cfg_t c);
    return c.par[2];
  endfunction

  function automatic logic par_value(logic [7:0] d, frame_cfg_t c);
    logic [7:0] m;
    m = d & data_mask(c.wlen);
    case (c.par)
      PAR_ODD:  return ~^m;
      PAR_EVEN: return ^m;
      PAR_MARK: return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic logic [11:0] build_frame(logic [7:0] d, frame_cfg_t c);
    logic [11:0] f;
    logic [3:0]  w;
    f    = '1;
    f[0] = 1'b0;
    w    = data_bits(c.wlen);
    for (int i = 0; i < 8; i++) begin
      if (i < int'(w)) f[i+1] = d[i];
    end
    if (has_par(c)) f[w + 4'd1] = par_value(d, c);
    return f;
  endfunction

  function automatic logic [3:0] frame_len(frame_cfg_t c);
    return 4'd2 + data_bits(c.wlen) + {3'b000, has_par(c)} + {3'b000, c.two_stop};
  endfunction
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter  int DEPTH = 16,
  parameter  int WIDTH = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic             push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rp_q];
  assign count   = cnt_q;

  always_comb begin
    wp_n  = push_ok ? AW'(wp_q + 1'b1) : wp_q;
    rp_n  = pop_ok  ? AW'(rp_q + 1'b1) : rp_q;
    cnt_n = cnt_q + CW'(push_ok) - CW'(pop_ok);
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  // R7: occupancy never passes the depth
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       fc_en,
  input  logic       cts,
  input  frame_cfg_t cfg,
  input  logic       fifo_empty,
  input  logic [7:0] fifo_data,
  output logic       pop,
  output logic       busy,
  output logic       line
);
  logic          busy_q, busy_n;
  logic [11:0]   frm_q, frm_n;
  logic [3:0]    len_q, len_n, idx_q, idx_n;
  logic [TW-1:0] tick_q, tick_n;

  assign pop  = !busy_q && en && !fifo_empty && (!fc_en || cts);
  assign busy = busy_q;
  assign line = busy_q ? frm_q[0] : 1'b1;

  always_comb begin
    busy_n = busy_q;
    frm_n  = frm_q;
    len_n  = len_q;
    idx_n  = idx_q;
    tick_n = tick_q;
    if (pop) begin
      busy_n = 1'b1;
      frm_n  = build_frame(fifo_data, cfg);
      len_n  = frame_len(cfg);
      idx_n  = '0;
      tick_n = '0;
    end else if (busy_q) begin
      if (tick_q == TW'(OSR - 1)) begin
        tick_n = '0;
        if (idx_q == len_q - 4'd1) begin
          busy_n = 1'b0;
        end else begin
          frm_n = {1'b1, frm_q[11:1]};
          idx_n = idx_q + 4'd1;
        end
      end else begin
        tick_n = tick_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      frm_q  <= '1;
      len_q  <= '0;
      idx_q  <= '0;
      tick_q <= '0;
    end else begin
      busy_q <= busy_n;
      frm_q  <= frm_n;
      len_q  <= len_n;
      idx_q  <= idx_n;
      tick_q <= tick_n;
    end
  end

  // R9: an idle transmitter stays idle while flow control holds it off
  a_r9_cts_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && fc_en && !cts) |=> !busy_q);
  // R2: every frame opens with a low start bit
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (line == 1'b0));
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       rx_in,
  input  frame_cfg_t cfg,
  output logic       push,
  output logic [7:0] data,
  output logic       err
);
  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS} rx_state_e;

  rx_state_e     st_q, st_n;
  logic          s1_q, s2_q;
  logic [TW-1:0] tick_q, tick_n;
  logic [3:0]    idx_q, idx_n, total, w;
  logic [15:0]   sh_q, sh_n;
  frame_cfg_t    cq_q, cq_n;
  logic          done_n, push_q, err_q, err_n;
  logic [7:0]    data_q, data_n;

  assign total = data_bits(cq_q.wlen) + {3'b000, has_par(cq_q)} + 4'd1;
  assign w     = data_bits(cq_q.wlen);
  assign push  = push_q;
  assign data  = data_q;
  assign err   = err_q;

  always_comb begin
    st_n   = st_q;
    tick_n = tick_q;
    idx_n  = idx_q;
    sh_n   = sh_q;
    cq_n   = cq_q;
    done_n = 1'b0;
    data_n = data_q;
    err_n  = err_q;
    case (st_q)
      S_IDLE: begin
        if (en && !s2_q) begin
          st_n   = S_START;
          tick_n = '0;
          cq_n   = cfg;
        end
      end
      S_START: begin
        if (tick_q == TW'(OSR / 2 - 1)) begin
          tick_n = '0;
          idx_n  = '0;
          st_n   = s2_q ? S_IDLE : S_BITS;
        end else begin
          tick_n = tick_q + 1'b1;
        end
      end
      default: begin
        if (tick_q == TW'(OSR - 1)) begin
          tick_n      = '0;
          sh_n[idx_q] = s2_q;
          if (idx_q == total - 4'd1) begin
            st_n   = S_IDLE;
            done_n = 1'b1;
            data_n = sh_n[7:0] & data_mask(cq_q.wlen);
            err_n  = !sh_n[w + {3'b000, has_par(cq_q)}] ||
                     (has_par(cq_q) && (sh_n[w] != par_value(data_n, cq_q)));
          end else begin
            idx_n = idx_q + 4'd1;
          end
        end else begin
          tick_n = tick_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      st_q   <= S_IDLE;
      tick_q <= '0;
      idx_q  <= '0;
      sh_q   <= '1;
      cq_q   <= '0;
      push_q <= 1'b0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      s1_q   <= rx_in;
      s2_q   <= s1_q;
      st_q   <= st_n;
      tick_q <= tick_n;
      idx_q  <= idx_n;
      sh_q   <= sh_n;
      cq_q   <= cq_n;
      push_q <= done_n;
      data_q <= data_n;
      err_q  <= err_n;
    end
  end

  // R5: each received frame produces a single push
  a_r5_single_push: assert property (@(posedge clk) disable iff (!rst_n)
    push_q |=> !push_q);
endmodule

// File: rtl/mmio_uart.sv
module mmio_uart
  import uart_pkg::*;
#(
  parameter  int TX_DEPTH = 16,
  parameter  int RX_DEPTH = 16,
  localparam int TCW      = $clog2(TX_DEPTH) + 1,
  localparam int RCW      = $clog2(RX_DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        txd,
  input  logic        rxd,
  input  logic        cts_in,
  output logic        rts_out,
  output logic        irq
);
  localparam logic [3:0]  OFF_CTL = 4'h0, OFF_RXD = 4'h4, OFF_TXD = 4'h8, OFF_STS = 4'hC;
  localparam logic [31:0] CTL_MASK = 32'h001C_9077;

  logic [31:0]    ctl_q, ctl_n;
  logic           rip_q, tip_q, ovr_q, txe_q, ferr_q;
  logic           rip_n, tip_n, ovr_n, txe_n, ferr_n;
  logic           cts1_q, cts2_q;
  logic           wr_ctl, wr_tx, wr_st, rd_rx;
  frame_cfg_t     cfg;
  logic           tx_pop, tx_busy, tx_full, tx_empty, tx_line;
  logic [7:0]     tx_head, rx_head, rx_byte;
  logic [TCW-1:0] tx_cnt;
  logic [RCW-1:0] rx_cnt;
  logic           rx_push, rx_err, rx_full, rx_empty, ovr_set;
  logic           loop_en;

  assign wr_ctl  = bus_sel && bus_wr && (bus_addr == OFF_CTL);
  assign wr_tx   = bus_sel && bus_wr && (bus_addr == OFF_TXD);
  assign wr_st   = bus_sel && bus_wr && (bus_addr == OFF_STS);
  assign rd_rx   = bus_sel && !bus_wr && (bus_addr == OFF_RXD);
  assign cfg     = {ctl_q[1:0], ctl_q[2], ctl_q[6:4]};
  assign loop_en = ctl_q[20];
  assign ovr_set = rx_push && rx_full;

  uart_fifo #(.DEPTH(TX_DEPTH), .WIDTH(8)) u_txq (
    .clk, .rst_n, .push(wr_tx), .wdata(bus_wdata[7:0]), .pop(tx_pop),
    .rdata(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  uart_tx u_tx (
    .clk, .rst_n, .en(ctl_q[15]), .fc_en(ctl_q[12]), .cts(cts2_q), .cfg,
    .fifo_empty(tx_empty), .fifo_data(tx_head), .pop(tx_pop), .busy(tx_busy),
    .line(tx_line));

  uart_rx u_rx (
    .clk, .rst_n, .en(ctl_q[15]), .rx_in(loop_en ? tx_line : rxd), .cfg,
    .push(rx_push), .data(rx_byte), .err(rx_err));

  uart_fifo #(.DEPTH(RX_DEPTH), .WIDTH(8)) u_rxq (
    .clk, .rst_n, .push(rx_push), .wdata(rx_byte), .pop(rd_rx),
    .rdata(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  assign txd     = loop_en ? 1'b1 : tx_line;
  assign rts_out = !ctl_q[12] || ((RCW'(RX_DEPTH) - rx_cnt) > RCW'(2));
  assign irq     = (rip_q && ctl_q[18]) || (tip_q && ctl_q[19]);

  always_comb begin
    ctl_n  = wr_ctl ? (bus_wdata & CTL_MASK) : ctl_q;
    rip_n  = (rip_q  && !(wr_st && bus_wdata[0])) || !rx_empty;
    tip_n  = (tip_q  && !(wr_st && bus_wdata[1])) || (tx_cnt < TCW'(TX_DEPTH / 2));
    ovr_n  = (ovr_q  && !(wr_st && bus_wdata[2])) || ovr_set;
    txe_n  = (txe_q  && !(wr_st && bus_wdata[3])) || (wr_tx && tx_full);
    ferr_n = (ferr_q && !(wr_st && bus_wdata[4])) || (rx_push && rx_err);
  end

  always_comb begin
    case (bus_addr)
      OFF_CTL: bus_rdata = ctl_q;
      OFF_RXD: bus_rdata = {24'd0, rx_head};
      OFF_STS: bus_rdata = {15'd0, 6'(tx_cnt), tx_empty && !tx_busy, 1'b0, rts_out,
                            cts2_q, tx_full, rx_empty, ferr_q, txe_q, ovr_q, tip_q, rip_q};
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      rip_q  <= 1'b0;
      tip_q  <= 1'b0;
      ovr_q  <= 1'b0;
      txe_q  <= 1'b0;
      ferr_q <= 1'b0;
      cts1_q <= 1'b0;
      cts2_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_n;
      rip_q  <= rip_n;
      tip_q  <= tip_n;
      ovr_q  <= ovr_n;
      txe_q  <= txe_n;
      ferr_q <= ferr_n;
      cts1_q <= cts_in;
      cts2_q <= cts1_q;
    end
  end

  // R6: a write of one clears the overrun flag when no new overrun arrives
  a_r6_w1c_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && bus_wdata[2] && !ovr_set) |=> !ovr_q);
endmodule

// File: tb/tb_mmio_uart.sv
module tb_mmio_uart;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, bus_sel, bus_wr, rxd, cts_in;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        txd, rts_out, irq;
  int          n_chk = 0, n_fail = 0;
  logic        low_seen;

  mmio_uart dut (.clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata,
                 .bus_rdata, .txd, .rxd, .cts_in, .rts_out, .irq);

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) if (txd === 1'b0) low_seen = 1'b1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rxd = 1'b1; cts_in = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // Expected frame from the R2/R3 rules
  function automatic logic [11:0] exp_frame(input logic [7:0] d, input int wl, input int par, output int len);
    logic [11:0] f;
    int w, ones;
    logic pb;
    w = 5 + wl; f = '1; f[0] = 1'b0; ones = 0;
    for (int i = 0; i < w; i++) begin f[i+1] = d[i]; ones += int'(d[i]); end
    len = 2 + w + ((par >= 4) ? 1 : 0);
    case (par)
      4: pb = (ones % 2 == 0);
      5: pb = 1'b1;
      6: pb = (ones % 2 == 1);
      default: pb = 1'b0;
    endcase
    if (par >= 4) f[w+1] = pb;
    return f;
  endfunction

  task automatic capture(input int n, output logic [11:0] bits);
    bits = '1;
    @(negedge txd);
    repeat (4) @(posedge clk);
    #1;
    for (int i = 0; i < n; i++) begin
      bits[i] = txd;
      repeat (8) @(posedge clk);
      #1;
    end
  endtask

  task automatic send_serial(input logic [11:0] f, input int n);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rxd = f[i];
      repeat (8) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    bus_read(4'h0, v); check(v == 0, "R1 ctl", v, 0);
    bus_read(4'hC, v); check(v == 32'h5A2, "R1 status", v, 32'h5A2);
    check(txd == 1'b1, "R1 txd", {31'd0, txd}, 1);
    check(irq == 1'b0, "R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_tx_frame(input logic [7:0] d, input int wl, input int par, input bit two, input string tag);
    logic [11:0] got, exp;
    int len;
    do_reset();
    exp = exp_frame(d, wl, par, len);
    if (two) len++;
    bus_write(4'h0, 32'h8000 | wl | (two ? 32'h4 : 0) | (par << 4));
    bus_write(4'h8, {24'd0, d});
    capture(len, got);
    for (int i = len; i < 12; i++) begin got[i] = 1'b1; exp[i] = 1'b1; end
    check(got == exp, tag, {20'd0, got}, {20'd0, exp});
  endtask

  task automatic t_rx_basic();
    logic [31:0] v;
    int len;
    do_reset();
    bus_write(4'h0, 32'h8003);
    send_serial(exp_frame(8'h3C, 3, 0, len), len);
    bus_read(4'hC, v); check(v[5] == 1'b0, "R5 rx nonempty", v, 0);
    bus_read(4'h4, v); check(v[7:0] == 8'h3C, "R5 rx data", v, 32'h3C);
    bus_read(4'hC, v); check(v[5] == 1'b1, "R5 rx empty after pop", v, 32'h20);
  endtask

  task automatic t_rx_parity();
    logic [31:0] v;
    logic [11:0] f;
    int len;
    do_reset();
    bus_write(4'h0, 32'h8063);
    send_serial(exp_frame(8'h03, 3, 6, len), len);
    bus_read(4'hC, v); check(v[4] == 1'b0, "R6 good parity no error", v, 0);
    bus_read(4'h4, v); check(v[7:0] == 8'h03, "R3 rx even data", v, 3);
    f = exp_frame(8'h01, 3, 6, len);
    f[9] = ~f[9];
    send_serial(f, len);
    bus_read(4'hC, v); check(v[4] == 1'b1, "R6 parity error flagged", v, 32'h10);
    bus_write(4'hC, 32'h10);
    bus_read(4'hC, v); check(v[4] == 1'b0, "R6 error cleared by write one", v, 0);
  endtask

  task automatic t_glitch();
    logic [31:0] v;
    do_reset();
    bus_write(4'h0, 32'h8003);
    @(negedge clk); rxd = 1'b0;
    repeat (2) @(negedge clk); rxd = 1'b1;
    repeat (120) @(negedge clk);
    bus_read(4'hC, v); check(v[5] == 1'b1 && v[4] == 1'b0, "R11 glitch ignored", v, 32'h20);
  endtask

  task automatic t_loopback();
    logic [31:0] v;
    do_reset();
    bus_write(4'h0, 32'h10_8003);
    low_seen = 1'b0;
    bus_write(4'h8, 32'h5A);
    repeat (120) @(negedge clk);
    check(low_seen == 1'b0, "R4 txd held high", {31'd0, low_seen}, 0);
    bus_read(4'h4, v); check(v[7:0] == 8'h5A, "R4 loopback data", v, 32'h5A);
  endtask

  task automatic t_tx_full();
    logic [31:0] v;
    do_reset();
    bus_write(4'h0, 32'h3);
    for (int i = 0; i < 5; i++) bus_write(4'h8, i);
    bus_read(4'hC, v);
    check(v[16:11] == 5 && v[10] == 1'b0, "R10 level 5 not empty", v, 5 << 11);
    for (int i = 5; i < 16; i++) bus_write(4'h8, i);
    bus_read(4'hC, v);
    check(v[6] == 1'b1 && v[16:11] == 16 && v[3] == 1'b0, "R7 full at 16", v, (16 << 11) | 32'h40);
    bus_write(4'h8, 32'hEE);
    bus_read(4'hC, v);
    check(v[3] == 1'b1 && v[16:11] == 16, "R7 write when full dropped", v, 32'h8);
    bus_write(4'hC, 32'h8);
    bus_read(4'hC, v); check(v[3] == 1'b0, "R7 tx error cleared", v, 0);
  endtask

  task automatic t_cts();
    logic [31:0] v;
    logic [11:0] got, exp;
    int len;
    do_reset();
    cts_in = 1'b0;
    bus_write(4'h0, 32'h9003);
    low_seen = 1'b0;
    bus_write(4'h8, 32'h77);
    repeat (200) @(negedge clk);
    check(low_seen == 1'b0, "R9 held while CTS low", {31'd0, low_seen}, 0);
    bus_read(4'hC, v);
    check(v[16:11] == 1 && v[7] == 1'b0 && v[10] == 1'b0, "R9 status while held", v, 1 << 11);
    cts_in = 1'b1;
    exp = exp_frame(8'h77, 3, 0, len);
    capture(len, got);
    for (int i = len; i < 12; i++) got[i] = 1'b1;
    check(got == exp, "R9 frame after CTS", {20'd0, got}, {20'd0, exp});
    repeat (20) @(negedge clk);
    bus_read(4'hC, v); check(v[10] == 1'b1, "R10 transmitter empty", v, 32'h400);
  endtask

  task automatic t_rts();
    logic [31:0] v;
    do_reset();
    bus_write(4'h0, 32'h10_9003);
    for (int i = 0; i < 16; i++) bus_write(4'h8, 32'h40 + i);
    repeat (1500) @(negedge clk);
    bus_read(4'hC, v);
    check(rts_out == 1'b0 && v[8] == 1'b0, "R9 RTS low near full", v, 0);
    for (int i = 0; i < 3; i++) bus_read(4'h4, v);
    check(v[7:0] == 8'h42, "R5 order preserved", v, 32'h42);
    #1 check(rts_out == 1'b1, "R9 RTS high with 3 free", {31'd0, rts_out}, 1);
  endtask

  task automatic t_overrun();
    logic [31:0] v;
    do_reset();
    bus_write(4'h0, 32'h10_8003);
    for (int i = 0; i < 17; i++) bus_write(4'h8, 32'h10 + i);
    repeat (1500) @(negedge clk);
    bus_read(4'hC, v); check(v[2] == 1'b1, "R6 overrun flagged", v, 32'h4);
    bus_read(4'h4, v); check(v[7:0] == 8'h10, "R6 oldest kept on overrun", v, 32'h10);
    bus_write(4'hC, 32'h4);
    bus_read(4'hC, v); check(v[2] == 1'b0, "R6 overrun cleared", v, 0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    do_reset();
    bus_write(4'h0, 32'h8_8003);
    #1 check(irq == 1'b1, "R8 tx pending irq", {31'd0, irq}, 1);
    bus_write(4'h0, 32'h14_8003);
    #1 check(irq == 1'b0, "R8 no rx irq when empty", {31'd0, irq}, 0);
    bus_write(4'h8, 32'h5A);
    repeat (120) @(negedge clk);
    check(irq == 1'b1, "R8 rx irq", {31'd0, irq}, 1);
    bus_read(4'h4, v);
    #1 check(irq == 1'b1, "R8 rx pending sticky", {31'd0, irq}, 1);
    bus_write(4'hC, 32'h1);
    #1 check(irq == 1'b0, "R8 rx pending cleared", {31'd0, irq}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_tx_frame(8'hA5, 3, 0, 1'b0, "R2 8 bit no parity");
    t_tx_frame(8'h13, 0, 4, 1'b1, "R3 5 bit odd two stop");
    t_tx_frame(8'h41, 2, 5, 1'b0, "R3 7 bit mark");
    t_tx_frame(8'h2D, 1, 6, 1'b0, "R3 6 bit even");
    t_tx_frame(8'hC3, 3, 7, 1'b1, "R3 8 bit space two stop");
    t_rx_basic();
    t_rx_parity();
    t_glitch();
    t_loopback();
    t_tx_full();
    t_cts();
    t_rts();
    t_overrun();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule